// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block is the digital half of a successive-approximation analog-to-digital converter. A one-cycle high pulse on the start input begins a conversion. The block then searches the code space for the input one bit per clock, starting at the most significant bit and working down. In each conversion clock it drives a trial code to an external DAC. The trial code holds the bits already decided, a one in the bit under test, and zeros below it. At the next clock edge it samples an external comparator. A high comparator means the trial voltage is above the input, and the bit under test is then dropped. Otherwise the bit is kept.

After the last bit has been decided, the block puts the finished code on its data output and pulses its end-of-conversion line low for one clock. The code stays on the output until the next conversion completes. The DAC, the comparator and the sample-and-hold are outside the block. The code width is a parameter.

Top module: `sar_sequencer`

## Requirements
- R1: When `start_i` is high at a clock edge while the block is idle, a conversion begins. In the next cycle `trial_o` carries only its most significant bit set, and `busy_o` is high.
- R2: In every conversion cycle, `trial_o` equals the bits decided so far, with a one in the bit under test and zeros in all lower bits.
- R3: Exactly one bit is decided per clock. The bit under test moves from bit WIDTH-1 down to bit 0, one position per cycle.
- R4: If `cmp_high_i` is 1 at the edge that closes a conversion cycle, the bit under test becomes 0. If it is 0, that bit becomes 1. With an ideal comparator (trial greater than input), the result is the input clamped to 2^WIDTH-1.
- R5: A conversion takes exactly WIDTH clocks. Take the edge that accepts start as edge 0. Then `busy_o` is high from edge 0 until edge WIDTH, and `eoc_n_o` is low in the cycle that follows edge WIDTH.
- R6: `eoc_n_o` is active low. It is low for exactly one cycle per conversion and high at all other times.
- R7: `code_o` takes the new result in the same cycle that `eoc_n_o` goes low. It then holds that value until the next conversion completes.
- R8: A start pulse received while a conversion is in progress is ignored. It does not change the trial sequence, the result or the completion time.
- R9: After a synchronous active-low reset, `busy_o` is 0, `eoc_n_o` is 1, and both `code_o` and `trial_o` are 0.
- R10: The code width is the parameter WIDTH, default 10, and it sets the width of `trial_o` and `code_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one bit decision per rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | High for one clock to request a conversion |
| cmp_high_i | input | 1 | Comparator result: 1 when the trial voltage is above the input |
| trial_o | output | WIDTH | Trial code driven to the external DAC |
| busy_o | output | 1 | High while a conversion is in progress |
| code_o | output | WIDTH | Last completed conversion result |
| eoc_n_o | output | 1 | End of conversion, one-cycle active-low pulse |

## Verification
After the edge that accepts start, the first trial code is due in the following cycle. The code for bit k is due k cycles after that. The result and the low end-of-conversion pulse are due exactly WIDTH edges after the accepting edge, and the line is back high one edge later. The bench drives inputs on falling edges and compares against a behavioural model that advances on rising edges. Every output is sampled on the falling edge, half a cycle after the register that drives it updates. Directed checks count falling edges from the start pulse, so each check lands in the cycle the requirements name.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
// Package: shared definitions for the successive approximation sequencer.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable types.
package sar_pkg;

    // Default number of result bits.
    localparam int SAR_DEFAULT_WIDTH = 10;

    // Sequencer phase: waiting for a start, or stepping through bits.
    typedef enum logic [0:0] {
        PHASE_IDLE = 1'b0,
        PHASE_CONV = 1'b1
    } sar_phase_e;

endpackage : sar_pkg

// File: rtl/sar_bit_ctrl.sv
`timescale 1ns/1ps
// Module: sar_bit_ctrl
// Walks a one-hot pointer from the MSB down to the LSB, one position per
// clock, once a start pulse is accepted while idle. It flags the cycle in
// which the LSB is under test so that the result can be latched.
// Assumes: WIDTH >= 2, start_i synchronous to clk, reset synchronous active low.
module sar_bit_ctrl
    import sar_pkg::*;
#(
    parameter int WIDTH = SAR_DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic [WIDTH-1:0] ptr_o,
    output logic             busy_o,
    output logic             accept_o,
    output logic             last_o
);

    localparam logic [WIDTH-1:0] MSB_ONEHOT = {1'b1, {(WIDTH-1){1'b0}}};

    sar_phase_e       phase_q;
    logic [WIDTH-1:0] ptr_q;

    // Purpose: a start counts only while idle; a start during a conversion is dropped.
    always_comb begin
        accept_o = start_i && (phase_q == PHASE_IDLE);
        busy_o   = (phase_q == PHASE_CONV);
        last_o   = busy_o && ptr_q[0];
        ptr_o    = ptr_q;
    end

    // Purpose: phase register and the pointer to the bit under test.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PHASE_IDLE;
            ptr_q   <= '0;
        end else begin
            case (phase_q)
                PHASE_IDLE: begin
                    if (start_i) begin
                        phase_q <= PHASE_CONV;
                        ptr_q   <= MSB_ONEHOT;
                    end
                end
                PHASE_CONV: begin
                    if (ptr_q[0]) begin
                        phase_q <= PHASE_IDLE;
                        ptr_q   <= '0;
                    end else begin
                        ptr_q <= ptr_q >> 1;
                    end
                end
                default: begin
                    phase_q <= PHASE_IDLE;
                    ptr_q   <= '0;
                end
            endcase
        end
    end

    AST_PTR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ptr_q)); // R3
    AST_FIRST_TRIAL_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> (ptr_q == MSB_ONEHOT)); // R1
    AST_ONE_BIT_PER_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !ptr_q[0]) |=> (ptr_q == ($past(ptr_q) >> 1))); // R3
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !ptr_q[0] && start_i) |=> busy_o); // R8
    AST_PTR_MATCHES_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o == (ptr_q != '0)); // R5

endmodule : sar_bit_ctrl

// File: rtl/sar_trial_reg.sv
`timescale 1ns/1ps
// Module: sar_trial_reg
// Holds the bits decided so far and forms the trial code for the DAC. It
// also forms the code that results once the bit under test has been decided
// from the comparator.
// Assumes: ptr_i is one-hot during a conversion and zero when idle, and
// cmp_high_i is settled for the current trial code by the clock edge.
module sar_trial_reg #(
    parameter int WIDTH = sar_pkg::SAR_DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] ptr_i,
    input  logic             cmp_high_i,
    output logic [WIDTH-1:0] trial_o,
    output logic [WIDTH-1:0] next_code_o
);

    logic [WIDTH-1:0] dec_q;
    logic [WIDTH-1:0] next_bits;
    logic             stepping;

    // Purpose: per-bit decision; the bit under test follows the inverted comparator.
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign next_bits[b] = ptr_i[b] ? ~cmp_high_i : dec_q[b];
    end

    // Purpose: trial code is the decided bits plus the bit under test.
    always_comb begin
        stepping    = |ptr_i;
        trial_o     = dec_q | ptr_i;
        next_code_o = next_bits;
    end

    // Purpose: clear the decided bits on a new conversion, then commit one bit per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else if (load_i) begin
            dec_q <= '0;
        end else if (stepping) begin
            dec_q <= next_bits;
        end
    end

    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        stepping |-> ((dec_q & (ptr_i | (ptr_i - 1'b1))) == '0)); // R2
    AST_CLEAR_WHEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (stepping && cmp_high_i) |=> ((dec_q & $past(ptr_i)) == '0)); // R4
    AST_KEEP_WHEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (stepping && !cmp_high_i) |=> ((dec_q & $past(ptr_i)) == $past(ptr_i))); // R4

endmodule : sar_trial_reg

// File: rtl/sar_result.sv
`timescale 1ns/1ps
// Module: sar_result
// Captures the finished code on the clock that decides the LSB and drives
// the one-cycle active-low completion pulse in the same cycle.
// Assumes: done_i is high for exactly one cycle per conversion.
module sar_result #(
    parameter int WIDTH = sar_pkg::SAR_DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_i,
    input  logic [WIDTH-1:0] next_code_i,
    output logic [WIDTH-1:0] code_o,
    output logic             eoc_n_o
);

    logic [WIDTH-1:0] code_q;
    logic             eoc_n_q;

    // Purpose: latch the result and drop the completion line for one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q  <= '0;
            eoc_n_q <= 1'b1;
        end else begin
            eoc_n_q <= ~done_i;
            if (done_i) begin
                code_q <= next_code_i;
            end
        end
    end

    assign code_o  = code_q;
    assign eoc_n_o = eoc_n_q;

    AST_EOC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !eoc_n_q |=> eoc_n_q); // R6
    AST_EOC_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> !eoc_n_q); // R5
    AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(code_q)); // R7

endmodule : sar_result

// File: rtl/sar_sequencer.sv
`timescale 1ns/1ps
// Module: sar_sequencer (top)
// Successive approximation sequencer. It decides one bit per clock, MSB
// first, which gives a fixed WIDTH-clock conversion. It takes a high start
// pulse and gives a one-cycle active-low end-of-conversion pulse.
// Assumes: an external DAC converts trial_o and an external comparator
// returns cmp_high_i for that trial before the next rising edge.
module sar_sequencer
    import sar_pkg::*;
#(
    parameter int WIDTH = SAR_DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cmp_high_i,
    output logic [WIDTH-1:0] trial_o,
    output logic             busy_o,
    output logic [WIDTH-1:0] code_o,
    output logic             eoc_n_o
);

    logic [WIDTH-1:0] ptr;
    logic [WIDTH-1:0] next_code;
    logic             accept;
    logic             last;

    // Purpose: bit pointer and phase control.
    sar_bit_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .ptr_o    (ptr),
        .busy_o   (busy_o),
        .accept_o (accept),
        .last_o   (last)
    );

    // Purpose: decided bits and the trial code.
    sar_trial_reg #(.WIDTH(WIDTH)) u_trial (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (accept),
        .ptr_i       (ptr),
        .cmp_high_i  (cmp_high_i),
        .trial_o     (trial_o),
        .next_code_o (next_code)
    );

    // Purpose: result register and completion pulse.
    sar_result #(.WIDTH(WIDTH)) u_result (
        .clk         (clk),
        .rst_n       (rst_n),
        .done_i      (last),
        .next_code_i (next_code),
        .code_o      (code_o),
        .eoc_n_o     (eoc_n_o)
    );

    AST_RESULT_WITH_EOC: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (code_o == $past(next_code))); // R7

endmodule : sar_sequencer

// File: tb/sar_sequencer_tb_top.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model advanced on rising edges and
// compared with every output on each falling edge, plus directed checks.
module sar_sequencer_tb_top;

    localparam int W    = 10;
    localparam int MAXC = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         cmp_high_i;
    logic [W-1:0] trial_o;
    logic         busy_o;
    logic [W-1:0] code_o;
    logic         eoc_n_o;

    int vin = 0;
    int n_tests = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    // Ideal comparator: high when the trial code is above the input.
    assign cmp_high_i = (int'(trial_o) > vin);

    sar_sequencer #(.WIDTH(W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .cmp_high_i (cmp_high_i),
        .trial_o    (trial_o),
        .busy_o     (busy_o),
        .code_o     (code_o),
        .eoc_n_o    (eoc_n_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model state.
    int m_bit = -1;
    int m_dec = 0;
    int m_code = 0;
    int m_eoc_n = 1;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_bit = -1; m_dec = 0; m_code = 0; m_eoc_n = 1;
        end else begin
            m_eoc_n = 1;
            if (m_bit >= 0) begin
                int t;
                t = m_dec | (1 << m_bit);
                if (!(t > vin)) m_dec = t;
                if (m_bit == 0) begin
                    m_code = m_dec;
                    m_eoc_n = 0;
                end
                m_bit--;
            end else if (start_i) begin
                m_dec = 0;
                m_bit = W - 1;
            end
        end
    end

    // Compare every output with the model on each falling edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R2 trial", int'(trial_o), (m_bit >= 0) ? (m_dec | (1 << m_bit)) : m_dec);
            check("R5 busy", int'(busy_o), (m_bit >= 0) ? 1 : 0);
            check("R6 eoc_n", int'(eoc_n_o), m_eoc_n);
            check("R7 code", int'(code_o), m_code);
        end
    end

    // One conversion with directed checks; optional start while busy.
    task automatic run_conv(input int v, input bit poke);
        int exp;
        vin = v;
        exp = (v > MAXC) ? MAXC : v;
        start_i = 1'b1;
        @(negedge clk);
        for (int k = 0; k < W; k++) begin
            start_i = 1'b0;
            if (k == 0) check("R1 first trial", int'(trial_o), 1 << (W - 1));
            check("R3 bit under test", int'(trial_o[W-1-k]), 1);
            check("R3 lower bits zero", int'(trial_o) & ((1 << (W - 1 - k)) - 1), 0);
            if (poke && k == 3) start_i = 1'b1;
            @(negedge clk);
        end
        check("R5 eoc after WIDTH clocks", int'(eoc_n_o), 0);
        check("R4 result", int'(code_o), exp);
        if (poke) check("R8 start ignored result", int'(code_o), exp);
        @(negedge clk);
        check("R6 eoc back high", int'(eoc_n_o), 1);
        check("R7 code held", int'(code_o), exp);
        check("R5 busy low after end", int'(busy_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset busy", int'(busy_o), 0);
        check("R9 reset eoc_n", int'(eoc_n_o), 1);
        check("R9 reset code", int'(code_o), 0);
        check("R9 reset trial", int'(trial_o), 0);
        check("R10 width", $bits(code_o), 10);
        rst_n = 1'b1;
        @(negedge clk);
        run_conv(429, 0);
        run_conv(0, 0);
        run_conv(MAXC, 0);
        run_conv(2000, 0);
        run_conv(512, 0);
        run_conv(511, 0);
        run_conv(1, 1);
        run_conv(321, 1);
        // Idle gap: code must hold with no start (R7).
        repeat (5) @(negedge clk);
        check("R7 code held while idle", int'(code_o), 321);
        for (int i = 0; i < 20; i++) begin
            run_conv($urandom_range(0, 1100), i[0]);
        end
        // Reset mid-conversion returns to the reset state (R9).
        vin = 700;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset mid busy", int'(busy_o), 0);
        check("R9 reset mid code", int'(code_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_conv(700, 0);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule : sar_sequencer_tb_top